// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block decides one relation between two 32-bit IEEE 754 single-precision operands. The caller picks the relation with a 3-bit condition code. One clock later the block returns a single bit, ready to be written into an integer register. There are six relations: equal, not equal, less, less-or-equal, greater and greater-or-equal.

Sign, exponent and fraction are packed from the most significant bit down, and the exponent is biased. Two values of the same sign therefore order exactly like the unsigned integers in their low 31 bits. The block reuses one unsigned magnitude comparator for that reason. Around it, small pieces of logic handle the sign, treat the two zeros as equal, and make NaN operands unordered.

Each operand passes through its own classifier, which finds its sign, magnitude, zero and NaN status. An ordering stage reduces the pair to one of four outcomes: less, equal, greater or unordered. A two-process register stage then selects the requested relation and holds it together with a valid flag.

Top module: `fpcmp_unit`

## Requirements
- R1: For non-NaN operands whose 32-bit patterns are identical, eq (code 0), le (3) and ge (5) return 1, and ne (1), lt (2) and gt (4) return 0.
- R2: When both operands are non-negative and not NaN, they order as unsigned integers on bits 30:0.
- R3: When both operands have sign bit 31 set and are not NaN, the ordering of bits 30:0 is reversed.
- R4: When the signs differ and the operands are not both zero, the operand with sign bit 0 is the greater one.
- R5: +0 (0x00000000) and -0 (0x80000000) are equal: eq, le and ge return 1, and ne, lt and gt return 0.
- R6: An operand is NaN when bits 30:23 are all ones and bits 22:0 are nonzero. If either operand is NaN, ne returns 1 and the other five relations return 0, even when the two patterns are identical.
- R7: The condition codes are 0=eq, 1=ne, 2=lt, 3=le, 4=gt, 5=ge. Codes 6 and 7 return 0 for any operands.
- R8: Infinities (exponent all ones, fraction zero) are ordered against finite values and against each other: -inf < every finite value < +inf, and +inf equals +inf.
- R9: After reset, out_vld and result are 0. A cycle with in_vld high produces out_vld high with its result on the following cycle. A cycle with in_vld low produces out_vld low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands and condition are valid this cycle |
| op_a | input | 32 | Left operand, single precision |
| op_b | input | 32 | Right operand, single precision |
| cond_sel | input | 3 | Relation code (0=eq,1=ne,2=lt,3=le,4=gt,5=ge) |
| out_vld | output | 1 | Result is valid |
| result | output | 1 | 1 when op_a (relation) op_b holds |

## Verification
The NaN override and the magnitude comparator act in the same cycle. An unordered operand still has a bit pattern that the comparator ranks as below, equal to or above the other operand. The bench provokes this by pairing a NaN with itself, with smaller patterns and with larger patterns under all six codes. It judges the result against a reference that checks for NaN before it computes any ordering. The signed-zero rule is exercised the same way: the zero rule must override the sign-differs rule in the cycle where both apply.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [2:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_LT = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_cond_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic unord;
    } cmp_order_t;

    typedef struct packed {
        logic vld;
        logic res;
    } cmp_stage_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W = EXP_W + FRAC_W,
    localparam int WORD_W = MAG_W + 1
) (
    input  logic [WORD_W-1:0] val,
    output logic              sign,
    output logic [MAG_W-1:0]  mag,
    output logic              is_zero,
    output logic              is_nan
);

    logic exp_ones;

    always_comb begin
        sign     = val[WORD_W-1];
        mag      = val[MAG_W-1:0];
        exp_ones = &val[MAG_W-1:FRAC_W];
        is_zero  = (mag == '0);
        is_nan   = exp_ones && (val[FRAC_W-1:0] != '0);
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             zero_a,
    input  logic             nan_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_b,
    input  logic             nan_b,
    output cmp_order_t       order
);

    logic mag_lt;
    logic mag_eq;
    logic both_zero;
    logic lt_raw;

    always_comb begin
        mag_lt    = (mag_a < mag_b);
        mag_eq    = (mag_a == mag_b);
        both_zero = zero_a && zero_b;

        if (sign_a == sign_b) begin
            lt_raw = sign_a ? (!mag_lt && !mag_eq) : mag_lt;
        end else begin
            lt_raw = sign_a && !both_zero;
        end

        order.unord = nan_a || nan_b;
        order.eq    = !order.unord && (both_zero || (sign_a == sign_b && mag_eq));
        order.lt    = !order.unord && !order.eq && lt_raw;
        order.gt    = !order.unord && !order.eq && !lt_raw;
    end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W  = EXP_W + FRAC_W,
    localparam int WORD_W = MAG_W + 1,
    localparam int N_OPS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [2:0]        cond_sel,
    output logic              out_vld,
    output logic              result
);

    logic [WORD_W-1:0] ops    [N_OPS];
    logic              sgn    [N_OPS];
    logic [MAG_W-1:0]  mag    [N_OPS];
    logic              zro    [N_OPS];
    logic              nan    [N_OPS];
    cmp_order_t        order;
    cmp_stage_t        stage_d, stage_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val     (ops[gi]),
            .sign    (sgn[gi]),
            .mag     (mag[gi]),
            .is_zero (zro[gi]),
            .is_nan  (nan[gi])
        );
    end

    fpcmp_order #(.MAG_W(MAG_W)) u_ord (
        .sign_a (sgn[0]), .mag_a (mag[0]), .zero_a (zro[0]), .nan_a (nan[0]),
        .sign_b (sgn[1]), .mag_b (mag[1]), .zero_b (zro[1]), .nan_b (nan[1]),
        .order  (order)
    );

    always_comb begin
        stage_d.vld = in_vld;
        stage_d.res = 1'b0;
        if (in_vld) begin
            case (cond_sel)
                CMP_EQ:  stage_d.res = order.eq;
                CMP_NE:  stage_d.res = !order.eq;
                CMP_LT:  stage_d.res = order.lt;
                CMP_LE:  stage_d.res = order.lt || order.eq;
                CMP_GT:  stage_d.res = order.gt;
                CMP_GE:  stage_d.res = order.gt || order.eq;
                default: stage_d.res = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_vld = stage_q.vld;
    assign result  = stage_q.res;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({order.lt, order.eq, order.gt, order.unord}) == 1); // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R9

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && !result); // R9

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cond_sel > 3'd5) |=> !result); // R7

    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (nan[0] || nan[1]) && cond_sel <= 3'd5)
            |=> (result == ($past(cond_sel) == CMP_NE))); // R6

    AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (zro[0] && zro[1]) |-> order.eq); // R5

endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  c;
        bit          exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [31:0] op_a, op_b;
    logic [2:0]  cond_sel;
    logic        out_vld, result;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    fpcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b), .cond_sel(cond_sel),
        .out_vld(out_vld), .result(result)
    );

    function automatic bit is_nan_f(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    function automatic logic [31:0] key_f(logic [31:0] v);
        if (v[30:0] == 31'd0) return 32'h8000_0000;
        if (v[31])            return ~v;
        return v | 32'h8000_0000;
    endfunction

    function automatic bit model(logic [31:0] a, logic [31:0] b, logic [2:0] c);
        logic [31:0] ka, kb;
        if (c > 3'd5) return 1'b0;
        if (is_nan_f(a) || is_nan_f(b)) return (c == 3'd1);
        ka = key_f(a);
        kb = key_f(b);
        case (c)
            3'd0: return ka == kb;
            3'd1: return ka != kb;
            3'd2: return ka <  kb;
            3'd3: return ka <= kb;
            3'd4: return ka >  kb;
            default: return ka >= kb;
        endcase
    endfunction

    task automatic fail_line(string tag, string what, int act, int exp);
        n_fail++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] c,
                         bit exp, string tag);
        item_t it;
        @(negedge clk);
        in_vld   = 1'b1;
        op_a     = a;
        op_b     = b;
        cond_sel = c;
        it.a = a; it.b = b; it.c = c; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive_m(logic [31:0] a, logic [31:0] b, logic [2:0] c, string tag);
        drive(a, b, c, model(a, b, c), tag);
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && out_vld) begin
            n_tests++;
            if (sb_q.size() == 0) begin
                fail_line("R9", "unexpected out_vld", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (result !== it.exp)
                    $display("FAIL %s a=%h b=%h c=%0d actual=%0d expected=%0d",
                             it.tag, it.a, it.b, it.c, result, it.exp);
                if (result !== it.exp) n_fail++;
            end
        end
    end

    initial begin
        logic [31:0] lf;
        rst_n = 1'b0; in_vld = 1'b0; op_a = '0; op_b = '0; cond_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (out_vld !== 1'b0 || result !== 1'b0) fail_line("R9", "reset state", out_vld, 0);
        rst_n = 1'b1;

        // R1 identical patterns
        drive(32'h3FC0_0000, 32'h3FC0_0000, 3'd0, 1, "R1");
        drive(32'h3FC0_0000, 32'h3FC0_0000, 3'd1, 0, "R1");
        drive(32'hC120_0000, 32'hC120_0000, 3'd3, 1, "R1");
        drive(32'hC120_0000, 32'hC120_0000, 3'd2, 0, "R1");
        // R2 positive ordering
        drive(32'h3F80_0000, 32'h4000_0000, 3'd2, 1, "R2");
        drive(32'h3F80_0000, 32'h4000_0000, 3'd4, 0, "R2");
        drive(32'h4000_0000, 32'h3F80_0000, 3'd5, 1, "R2");
        drive(32'h0000_0001, 32'h0000_0002, 3'd3, 1, "R2");
        // R3 negative ordering reversed
        drive(32'hBF80_0000, 32'hBF00_0000, 3'd2, 1, "R3");
        drive(32'hBF80_0000, 32'hBF00_0000, 3'd4, 0, "R3");
        drive(32'hBF00_0000, 32'hBF80_0000, 3'd5, 1, "R3");
        // R4 mixed signs
        drive(32'hBF80_0000, 32'h0000_0001, 3'd2, 1, "R4");
        drive(32'h0000_0000, 32'h8000_0001, 3'd4, 1, "R4");
        drive(32'h8000_0001, 32'h0000_0000, 3'd5, 0, "R4");
        // R5 signed zeros
        for (int c = 0; c < 6; c++) begin
            drive(32'h0000_0000, 32'h8000_0000, 3'(c), (c == 0 || c == 3 || c == 5), "R5");
            drive(32'h8000_0000, 32'h0000_0000, 3'(c), (c == 0 || c == 3 || c == 5), "R5");
        end
        // R6 NaN unordered, against smaller, larger and itself
        for (int c = 0; c < 6; c++) begin
            drive(32'h7FC0_0000, 32'h3F80_0000, 3'(c), (c == 1), "R6");
            drive(32'h3F80_0000, 32'hFFC0_0001, 3'(c), (c == 1), "R6");
            drive(32'h7F80_0001, 32'h7F80_0001, 3'(c), (c == 1), "R6");
            drive(32'h7FC0_0000, 32'h7F80_0000, 3'(c), (c == 1), "R6");
        end
        // R7 reserved codes
        drive(32'h3F80_0000, 32'h3F80_0000, 3'd6, 0, "R7");
        drive(32'h3F80_0000, 32'h4000_0000, 3'd7, 0, "R7");
        drive(32'h7FC0_0000, 32'h3F80_0000, 3'd6, 0, "R7");
        // R8 infinities
        drive(32'h7F80_0000, 32'h7F7F_FFFF, 3'd4, 1, "R8");
        drive(32'hFF80_0000, 32'hFF7F_FFFF, 3'd2, 1, "R8");
        drive(32'h7F80_0000, 32'h7F80_0000, 3'd0, 1, "R8");
        drive(32'hFF80_0000, 32'h7F80_0000, 3'd3, 1, "R8");
        // R9 gap between items
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
        #2;
        n_tests++;
        if (out_vld !== 1'b0) fail_line("R9", "idle out_vld", out_vld, 0);
        // R2/R3/R4 mixed patterns against the model
        lf = 32'h1357_9BDF;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b  = (i % 4 == 0) ? a : (i % 4 == 1) ? (a ^ 32'h0000_0010) : lf;
            drive_m(a, b, 3'(i % 8), "R2");
        end
        @(negedge clk);
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        n_tests++;
        if (sb_q.size() != 0) fail_line("R9", "items left", sb_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_tests++;
            fail_line("R9", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule